// File: doc/BRIEF.md
# NAND Command and Address Latch

This block is the device-side front end of a small-page NAND flash. It watches an 8-bit I/O bus together with chip enable, write enable and two byte-type strobes (command latch and address latch). A byte is taken when write enable goes from low to high while chip enable is low. The write-enable rising edge is first brought into the system clock by a synchronizer and then edge-detected. Each byte is sorted as a command when only the command strobe is high, or as an address byte when only the address strobe is high. If both strobes are high, or neither is, the byte is discarded.

Three address cycles build a 25-bit byte address. Cycle 1 gives the column bits 7..0. Cycle 2 gives row bits 16..9 and cycle 3 gives row bits 24..17. Row bits 24..9 select one of 65,536 pages of 528 bytes each: bits 24..14 pick one of 2,048 blocks, and bits 13..9 pick one of 32 pages inside that block. Bit 8 never appears on the bus. The read opcodes 00h and 01h set it to choose the lower or upper 256-byte half of the page's 512-byte main area. Every accepted command is reported on a one-clock pulse together with its opcode. A one-clock pulse also marks that the third address cycle has been captured.

Top module: `nal_top`

## Requirements
- R1: After reset `addr_o` is all zeros and `cmd_valid_o` and `addr_done_o` are low.
- R2: A byte taken with the command strobe high and the address strobe low is a command. It raises `cmd_valid_o` for exactly one clock, with the byte on `cmd_o`.
- R3: Address bytes fill fixed positions in order. Cycle 1 loads `addr_o[7:0]`, cycle 2 loads `addr_o[16:9]` and cycle 3 loads `addr_o[24:17]`.
- R4: Command 00h clears `addr_o[8]` and command 01h sets it. Any other command leaves `addr_o[8]` unchanged.
- R5: Address bytes after the third one, and before the next command, leave `addr_o` unchanged.
- R6: Every command restarts the cycle count, so the next address byte is treated as cycle 1.
- R7: `addr_done_o` is high for exactly one clock for each third address cycle, and at no other time.
- R8: A byte taken with both strobes high, or both low, changes neither `addr_o` nor the cycle count, and raises no pulse.
- R9: Bytes presented while chip enable (`ce_ni`) is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low; a byte is taken on its rising edge |
| cle_i | input | 1 | Command latch strobe |
| ale_i | input | 1 | Address latch strobe |
| io_i | input | 8 | Bus byte |
| cmd_valid_o | output | 1 | One-clock pulse for each accepted command |
| cmd_o | output | 8 | Opcode of the last accepted command |
| addr_done_o | output | 1 | One-clock pulse when the third address cycle is captured |
| addr_o | output | 25 | Assembled byte address; bit 8 is the half-page select |

## Verification
The bench builds the block with its defaults: an 8-bit bus, three address cycles and a two-stage synchronizer. This gives the full 25-bit address, with bit 8 placed between the column byte and the row bytes. With three cycles the cycle counter can reach its saturated state after a short burst of address bytes, so dropped extra cycles, restarts by a command and discarded bytes can all be mixed in random sequences.

// File: rtl/nal_pkg.sv
package nal_pkg;
  typedef enum logic [1:0] {
    BK_NONE = 2'd0,
    BK_CMD  = 2'd1,
    BK_ADDR = 2'd2
  } byte_kind_e;

  localparam logic [7:0] OP_HALF_LO = 8'h00;
  localparam logic [7:0] OP_HALF_HI = 8'h01;
endpackage

// File: rtl/nal_edge_sync.sv
module nal_edge_sync #(
  parameter int unsigned W      = 12,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  input  logic         we_ni,
  output logic [W-1:0] sync_o,
  output logic         we_rise_o
);
  logic [W:0] stage_q [STAGES];
  logic       we_last_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= {1'b1, {W{1'b0}}};
      else if (s == 0) stage_q[s] <= {we_ni, async_i};
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) we_last_q <= 1'b1;
    else         we_last_q <= stage_q[STAGES-1][W];
  end

  assign sync_o    = stage_q[STAGES-1][W-1:0];
  assign we_rise_o = stage_q[STAGES-1][W] & ~we_last_q;

  a_r2_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_rise_o |=> !we_rise_o);
endmodule

// File: rtl/nal_classify.sv
module nal_classify
  import nal_pkg::*;
(
  input  logic       stb_i,
  input  logic       ce_ni,
  input  logic       cle_i,
  input  logic       ale_i,
  output byte_kind_e kind_o
);
  always_comb begin
    kind_o = BK_NONE;
    if (stb_i && !ce_ni) begin
      if (cle_i && !ale_i)      kind_o = BK_CMD;
      else if (ale_i && !cle_i) kind_o = BK_ADDR;
    end
  end
endmodule

// File: rtl/nal_addr_asm.sv
module nal_addr_asm #(
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned CYCLES = 3,
  localparam int unsigned ADDR_W = BUS_W * CYCLES + 1,
  localparam int unsigned CNT_W  = $clog2(CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_stb_i,
  input  logic              addr_stb_i,
  input  logic [BUS_W-1:0]  data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);
  import nal_pkg::*;

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q;

  function automatic int unsigned slice_lo(int unsigned k);
    return (k == 0) ? 0 : k * BUS_W + 1;  // skip half-select bit
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cmd_stb_i) begin
        cnt_q <= '0;
        if (data_i == BUS_W'(OP_HALF_LO))      addr_q[BUS_W] <= 1'b0;
        else if (data_i == BUS_W'(OP_HALF_HI)) addr_q[BUS_W] <= 1'b1;
      end else if (addr_stb_i && cnt_q != CNT_FULL) begin
        for (int unsigned k = 0; k < CYCLES; k++) begin
          if (cnt_q == CNT_W'(k)) addr_q[slice_lo(k) +: BUS_W] <= data_i;
        end
        cnt_q  <= cnt_q + 1'b1;
        done_q <= (cnt_q == CNT_LAST);
      end
    end
  end

  assign addr_o = addr_q;
  assign done_o = done_q;

  a_r5_hold_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_stb_i && cnt_q == CNT_FULL) |=> $stable(addr_q) && !done_q);
  a_r6_cmd_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stb_i |=> cnt_q == '0);
  a_r7_done_at_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> cnt_q == CNT_FULL);
  a_r4_half_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_stb_i && data_i == BUS_W'(OP_HALF_HI)) |=> addr_q[BUS_W]);
  a_r4_half_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_stb_i && data_i == BUS_W'(OP_HALF_LO)) |=> !addr_q[BUS_W]);
endmodule

// File: rtl/nal_top.sv
module nal_top #(
  parameter int unsigned BUS_W       = 8,
  parameter int unsigned CYCLES      = 3,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned ADDR_W = BUS_W * CYCLES + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              cle_i,
  input  logic              ale_i,
  input  logic [BUS_W-1:0]  io_i,
  output logic              cmd_valid_o,
  output logic [BUS_W-1:0]  cmd_o,
  output logic              addr_done_o,
  output logic [ADDR_W-1:0] addr_o
);
  import nal_pkg::*;

  localparam int unsigned SW = BUS_W + 3;

  logic [SW-1:0]    sync_w;
  logic             we_rise;
  byte_kind_e       kind;
  logic             cmd_valid_q;
  logic [BUS_W-1:0] cmd_q;

  nal_edge_sync #(.W(SW), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .async_i  ({ce_ni, cle_i, ale_i, io_i}),
    .we_ni    (we_ni),
    .sync_o   (sync_w),
    .we_rise_o(we_rise)
  );

  nal_classify i_class (
    .stb_i (we_rise),
    .ce_ni (sync_w[BUS_W+2]),
    .cle_i (sync_w[BUS_W+1]),
    .ale_i (sync_w[BUS_W]),
    .kind_o(kind)
  );

  nal_addr_asm #(.BUS_W(BUS_W), .CYCLES(CYCLES)) i_asm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_stb_i (kind == BK_CMD),
    .addr_stb_i(kind == BK_ADDR),
    .data_i    (sync_w[BUS_W-1:0]),
    .addr_o    (addr_o),
    .done_o    (addr_done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_q <= 1'b0;
      cmd_q       <= '0;
    end else begin
      cmd_valid_q <= (kind == BK_CMD);
      if (kind == BK_CMD) cmd_q <= sync_w[BUS_W-1:0];
    end
  end

  assign cmd_valid_o = cmd_valid_q;
  assign cmd_o       = cmd_q;

  a_r8_drop_conflict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_rise && sync_w[BUS_W+1] == sync_w[BUS_W]) |=> $stable(addr_o) && !cmd_valid_o && !addr_done_o);
  a_r9_ce_high_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_rise && sync_w[BUS_W+2]) |=> $stable(addr_o) && !cmd_valid_o);
  a_r2_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);
endmodule

// File: tb/test_nal_top.sv
module test_nal_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ce_ni = 1'b1, we_ni = 1'b1, cle_i = 1'b0, ale_i = 1'b0;
  logic [7:0]  io_i = '0;
  logic        cmd_valid_o, addr_done_o;
  logic [7:0]  cmd_o;
  logic [24:0] addr_o;

  int total = 0, bad = 0;
  int n_cmd = 0, n_done = 0;
  logic [24:0] m_addr = '0;
  int m_cnt = 0, m_cmd_pulses = 0, m_done_pulses = 0;
  logic [7:0] m_last_cmd = '0;

  always #10 clk_i = ~clk_i;

  nal_top i_nal_top (.*);

  always @(negedge clk_i) begin
    if (cmd_valid_o) n_cmd++;
    if (addr_done_o) n_done++;
  end

  initial begin
    #4_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void model(logic ce_n, logic cle, logic ale, logic [7:0] d);
    if (ce_n) return;
    if (cle && !ale) begin
      m_cnt = 0; m_cmd_pulses++; m_last_cmd = d;
      if (d == 8'h00) m_addr[8] = 1'b0;
      else if (d == 8'h01) m_addr[8] = 1'b1;
    end else if (ale && !cle && m_cnt < 3) begin
      case (m_cnt)
        0: m_addr[7:0] = d;
        1: m_addr[16:9] = d;
        default: begin m_addr[24:17] = d; m_done_pulses++; end
      endcase
      m_cnt++;
    end
  endfunction

  task automatic put(string tag, logic ce_n, logic cle, logic ale, logic [7:0] d);
    ce_ni = ce_n; cle_i = cle; ale_i = ale; io_i = d;
    repeat (2) @(posedge clk_i);
    we_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    we_ni = 1'b1;
    repeat (6) @(posedge clk_i);
    model(ce_n, cle, ale, d);
    @(negedge clk_i);
    chk({tag, " addr"}, 32'(addr_o), 32'(m_addr));
    chk({tag, " cmd pulses"}, n_cmd, m_cmd_pulses);
    chk({tag, " done pulses"}, n_done, m_done_pulses);
    chk({tag, " opcode"}, 32'(cmd_o), 32'(m_last_cmd));
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R1 reset addr", 32'(addr_o), 0);
    chk("R1 reset pulses", {cmd_valid_o, addr_done_o}, 0);
    rst_ni = 1'b1;
    // directed
    put("R2 cmd", 0, 1, 0, 8'h01);
    put("R4 half set", 0, 1, 0, 8'h01);
    put("R3 cyc1", 0, 0, 1, 8'hA5);
    put("R3 cyc2", 0, 0, 1, 8'h3C);
    put("R7 cyc3", 0, 0, 1, 8'hF0);
    chk("R3 full addr", 32'(addr_o), 32'({8'hF0, 8'h3C, 1'b1, 8'hA5}));
    put("R5 extra", 0, 0, 1, 8'h11);
    put("R5 extra2", 0, 0, 1, 8'h22);
    put("R4 other cmd", 0, 1, 0, 8'h80);
    put("R8 both", 0, 1, 1, 8'h00);
    put("R8 none", 0, 0, 0, 8'h55);
    put("R9 ce high cmd", 1, 1, 0, 8'h00);
    put("R9 ce high addr", 1, 0, 1, 8'h77);
    put("R6 restart", 0, 0, 1, 8'h9E);
    put("R4 half clr", 0, 1, 0, 8'h00);
    put("R6 cyc1 again", 0, 0, 1, 8'h42);
    // random
    for (int i = 0; i < 300; i++) begin
      int k = $urandom_range(0, 9);
      logic [7:0] d = 8'($urandom);
      if (k < 2)      put("R4 rnd half", 0, 1, 0, {7'd0, d[0]});
      else if (k < 3) put("R2 rnd cmd", 0, 1, 0, d);
      else if (k < 7) put("R3 rnd addr", 0, 0, 1, d);
      else if (k < 8) put("R8 rnd drop", 0, d[0], d[0], d);
      else            put("R9 rnd ce", 1, d[0], ~d[0], d);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule